// File: doc/BRIEF.md
# Configurable SPI Byte Master

This block is a single-master SPI engine that exchanges one byte in full duplex with one of four slaves. For each transfer the requester presents a clock polarity, a clock phase, a serial clock divider value, a two-bit slave address and the byte to send, then pulses `enable`. The block latches all of these, pulls the addressed select line low and runs sixteen serial clock edges. It shifts its byte out MSB first on `mosi` while it collects the slave's byte from `miso`. At the end it raises the select line, drops `busy` and presents the received byte.

A two-state controller (idle, execute) sequences the transfer. In the execute state a divider counter sets the serial clock half period, and a bit counter together with a half-cycle flag sets which edges sample and which edges shift. The datapath holds the latched configuration, the transmit and receive shift registers, the serial clock register, the select lines and the output byte.

Top module: `spi_byte_master`

## Requirements
- R1: While `rstN` is low (asynchronous, active low), `busy`=0, `ssN`=4'b1111, `sclk`=0 and `rxByte`=0.
- R2: `enable`=1 seen at a clock edge while idle starts a transfer. `busy` is 1 from that edge on, and `ssN` equals ~(1<<`slaveAddr`), so exactly the addressed bit is 0. `enable` seen while busy has no effect: the running transfer keeps its length and data.
- R3: Each transfer exchanges 8 bits MSB first in both directions. The slave receives `txByte`, and `rxByte` ends equal to the byte the slave sent.
- R4: A transfer makes exactly 16 `sclk` edges, one every `clkDiv`+1 system clocks. `busy` stays high for 16*(`clkDiv`+1) clocks in total and falls on the clock of the last edge.
- R5: With `cpha`=0 both sides sample on the leading (first, third, ...) `sclk` edges, and the first data bit is valid before the first edge. With `cpha`=1 they sample on the trailing edges, and data changes on the leading edges.
- R6: `sclk` rests at the latched `cpol` level when a transfer ends. While idle, `sclk` takes the value of the `cpol` input one clock later.
- R7: `cpol`, `cpha`, `clkDiv`, `slaveAddr` and `txByte` are latched when a transfer starts. Changing them during the transfer does not alter its timing, select line or data.
- R8: `rxByte` changes only on the clock where `busy` falls, and holds its value at all other times.
- R9: While `busy`=0 all four `ssN` lines are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Start request, taken when idle |
| cpol | input | 1 | Serial clock idle level for the next transfer |
| cpha | input | 1 | 0: sample on leading edges, 1: sample on trailing edges |
| clkDiv | input | 8 | Serial clock half period minus one, in system clocks |
| slaveAddr | input | 2 | Index of the slave to select |
| txByte | input | 8 | Byte to send |
| miso | input | 1 | Serial data from the slave |
| busy | output | 1 | High while a transfer runs |
| rxByte | output | 8 | Last received byte |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| ssN | output | 4 | Active-low slave selects |

## Verification
`busy` and the select line are due on the edge that takes `enable`. The bench therefore checks them at the next falling clock edge. `busy` falls, `rxByte` updates and the selects rise 16*(`clkDiv`+1) clocks after the start, so the bench counts busy cycles at falling edges and compares the total with that figure. A behavioural slave reacts to every `sclk` change in the mode the bench chose, so wrong sampling edges, wrong bit order or wrong edge counts show up as wrong bytes or counts. Stimulus includes inputs changed in mid-transfer and an extra `enable` pulse while busy, both checked against the undisturbed expected results.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
  typedef enum logic {ST_IDLE, ST_EXEC} sbmState_t;

  // strobes from control to datapath, valid for one clock
  typedef struct packed {
    logic start;
    logic toggle;
    logic sample;
    logic shift;
    logic finish;
  } sbmStrb_t;
endpackage

// File: rtl/sbm_ctrl.sv
module sbm_ctrl
  import sbm_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             cfgCpha,
  input  logic [DIV_W-1:0] cfgDiv,
  output logic             busy,
  output sbmStrb_t         strb
);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  sbmState_t        state;
  logic [DIV_W-1:0] divCnt;
  logic [BIT_W-1:0] bitCnt;
  logic             halfSel;  // 0: next edge is leading, 1: trailing
  logic             tick;

  assign busy = (state == ST_EXEC);
  assign tick = busy && (divCnt == cfgDiv);

  always_comb begin
    strb       = '0;
    strb.start = (state == ST_IDLE) && enable;
    if (tick) begin
      strb.toggle = 1'b1;
      strb.sample = (halfSel == cfgCpha);
      strb.shift  = (halfSel != cfgCpha) && !(cfgCpha && !halfSel && bitCnt == '0);
      strb.finish = halfSel && (bitCnt == LAST_BIT);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      divCnt  <= '0;
      bitCnt  <= '0;
      halfSel <= 1'b0;
    end else if (state == ST_IDLE) begin
      if (enable) begin
        state   <= ST_EXEC;
        divCnt  <= '0;
        bitCnt  <= '0;
        halfSel <= 1'b0;
      end
    end else if (tick) begin
      divCnt  <= '0;
      halfSel <= ~halfSel;
      if (halfSel) bitCnt <= bitCnt + 1'b1;
      if (strb.finish) state <= ST_IDLE;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(enable)); // R2

  AST_SAMPLE_XOR_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.sample && strb.shift)); // R5
endmodule

// File: rtl/sbm_datapath.sv
module sbm_datapath
  import sbm_pkg::*;
#(
  parameter int DIV_W      = 8,
  parameter int DATA_W     = 8,
  parameter int NUM_SLAVES = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  sbmStrb_t                      strb,
  input  logic                          busy,
  input  logic                          cpol,
  input  logic                          cpha,
  input  logic [DIV_W-1:0]              clkDiv,
  input  logic [$clog2(NUM_SLAVES)-1:0] slaveAddr,
  input  logic [DATA_W-1:0]             txByte,
  input  logic                          miso,
  output logic                          cfgCpha,
  output logic [DIV_W-1:0]              cfgDiv,
  output logic [DATA_W-1:0]             rxByte,
  output logic                          sclk,
  output logic                          mosi,
  output logic [NUM_SLAVES-1:0]         ssN
);
  logic              cfgCpol;
  logic [DATA_W-1:0] txShift;
  logic [DATA_W-1:0] rxShift;

  assign mosi = txShift[DATA_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgCpol <= 1'b0;
      cfgCpha <= 1'b0;
      cfgDiv  <= '0;
      txShift <= '0;
      rxShift <= '0;
      rxByte  <= '0;
      sclk    <= 1'b0;
      ssN     <= '1;
    end else if (strb.start) begin
      cfgCpol <= cpol;
      cfgCpha <= cpha;
      cfgDiv  <= clkDiv;
      txShift <= txByte;
      rxShift <= '0;
      sclk    <= cpol;
      ssN     <= ~(NUM_SLAVES'(1) << slaveAddr);
    end else if (!busy) begin
      sclk <= cpol;
    end else begin
      if (strb.toggle) sclk <= ~sclk;
      if (strb.sample) rxShift <= {rxShift[DATA_W-2:0], miso};
      if (strb.shift)  txShift <= {txShift[DATA_W-2:0], 1'b0};
      if (strb.finish) begin
        rxByte <= strb.sample ? {rxShift[DATA_W-2:0], miso} : rxShift;
        ssN    <= '1;
      end
    end
  end

  AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (&ssN)); // R9

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> ($countones(~ssN) == 1)); // R2

  AST_RX_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !$fell(busy) |-> $stable(rxByte)); // R8

  AST_SCLK_REST: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (sclk == cfgCpol)); // R6
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
  import sbm_pkg::*;
#(
  parameter int DIV_W      = 8,
  parameter int DATA_W     = 8,
  parameter int NUM_SLAVES = 4,
  localparam int ADDR_W    = $clog2(NUM_SLAVES)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  enable,
  input  logic                  cpol,
  input  logic                  cpha,
  input  logic [DIV_W-1:0]      clkDiv,
  input  logic [ADDR_W-1:0]     slaveAddr,
  input  logic [DATA_W-1:0]     txByte,
  input  logic                  miso,
  output logic                  busy,
  output logic [DATA_W-1:0]     rxByte,
  output logic                  sclk,
  output logic                  mosi,
  output logic [NUM_SLAVES-1:0] ssN
);
  sbmStrb_t         strb;
  logic             cfgCpha;
  logic [DIV_W-1:0] cfgDiv;

  sbm_ctrl #(.DIV_W(DIV_W), .DATA_W(DATA_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .enable(enable), .cfgCpha(cfgCpha),
    .cfgDiv(cfgDiv), .busy(busy), .strb(strb)
  );

  sbm_datapath #(.DIV_W(DIV_W), .DATA_W(DATA_W), .NUM_SLAVES(NUM_SLAVES)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .busy(busy), .cpol(cpol),
    .cpha(cpha), .clkDiv(clkDiv), .slaveAddr(slaveAddr), .txByte(txByte),
    .miso(miso), .cfgCpha(cfgCpha), .cfgDiv(cfgDiv), .rxByte(rxByte),
    .sclk(sclk), .mosi(mosi), .ssN(ssN)
  );

  AST_START_SELECTS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (ssN == ~(NUM_SLAVES'(1) << $past(slaveAddr)))); // R2
endmodule

// File: tb/spi_byte_master_tb.sv
module spi_byte_master_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic       cpol = 1'b0;
  logic       cpha = 1'b0;
  logic [7:0] clkDiv = '0;
  logic [1:0] slaveAddr = '0;
  logic [7:0] txByte = '0;
  logic       miso = 1'b0;
  logic       busy;
  logic [7:0] rxByte;
  logic       sclk;
  logic       mosi;
  logic [3:0] ssN;

  int nChecks = 0;
  int nFail = 0;

  // behavioural slave state
  logic       inXfer = 1'b0;
  logic       curCpol = 1'b0;
  logic       curCpha = 1'b0;
  logic [7:0] slvTx = '0;
  logic [7:0] slvRx = '0;
  logic       lead;
  int         idx = 0;
  int         edgeSeen = 0;

  always #2 clk = ~clk;

  spi_byte_master dut_i (
    .clk(clk), .rstN(rstN), .enable(enable), .cpol(cpol), .cpha(cpha),
    .clkDiv(clkDiv), .slaveAddr(slaveAddr), .txByte(txByte), .miso(miso),
    .busy(busy), .rxByte(rxByte), .sclk(sclk), .mosi(mosi), .ssN(ssN)
  );

  always @(sclk) begin
    if (inXfer) begin
      edgeSeen++;
      lead = (sclk != curCpol);
      if (lead ^ curCpha) slvRx = {slvRx[6:0], mosi};
      else if (idx >= 0) begin
        miso = slvTx[idx];
        idx--;
      end
    end
  end

  function automatic logic [3:0] selFor(input logic [1:0] a);
    return ~(4'b0001 << a);
  endfunction

  task automatic chk(input logic ok, input string what, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic xfer(input logic pol, input logic pha, input logic [7:0] div,
                      input logic [1:0] adr, input logic [7:0] tx,
                      input logic [7:0] sv, input bit disturb);
    int cyc;
    int guard;
    logic [7:0] prevRx;
    @(negedge clk);
    cpol = pol; cpha = pha; clkDiv = div; slaveAddr = adr; txByte = tx;
    curCpol = pol; curCpha = pha; slvTx = sv; slvRx = '0; edgeSeen = 0;
    idx = pha ? 7 : 6;
    miso = pha ? 1'b0 : sv[7];
    prevRx = rxByte;
    @(negedge clk);
    enable = 1'b1; inXfer = 1'b1;
    @(negedge clk);
    enable = 1'b0;
    chk(busy == 1'b1, "R2 busy after start", int'(busy), 1);
    chk(ssN == selFor(adr), "R2 select line", int'(ssN), int'(selFor(adr)));
    cyc = 1;
    guard = 0;
    while (busy && guard < 20000) begin
      if (disturb && cyc == 3) begin
        cpol = ~pol; cpha = ~pha; clkDiv = div + 8'd5;
        slaveAddr = adr + 2'd1; txByte = ~tx; enable = 1'b1;
      end
      if (cyc == 4) enable = 1'b0;
      if (cyc == 5) chk(rxByte == prevRx, "R8 rxByte held during transfer", int'(rxByte), int'(prevRx));
      @(negedge clk);
      guard++;
      if (busy) cyc++;
    end
    enable = 1'b0;
    inXfer = 1'b0;
    chk(guard < 20000, "watchdog R4 transfer end", guard, 0);
    chk(cyc == 16 * (int'(div) + 1), disturb ? "R7 R4 busy length" : "R4 busy length",
        cyc, 16 * (int'(div) + 1));
    chk(edgeSeen == 16, "R4 sclk edge count", edgeSeen, 16);
    chk(slvRx == tx, disturb ? "R7 R3 R5 slave got txByte" : "R3 R5 slave got txByte",
        int'(slvRx), int'(tx));
    chk(rxByte == sv, disturb ? "R7 R3 R5 rxByte" : "R3 R5 rxByte", int'(rxByte), int'(sv));
    chk(ssN == 4'hF, "R9 selects high after end", int'(ssN), 15);
    chk(sclk == pol, "R6 sclk rests at cpol", int'(sclk), int'(pol));
    @(negedge clk);
    chk(busy == 1'b0, "R2 no restart", int'(busy), 0);
    cpol = ~cpol;
    @(negedge clk);
    chk(sclk == cpol, "R6 idle sclk follows cpol", int'(sclk), int'(cpol));
    chk(rxByte == sv, "R8 rxByte held while idle", int'(rxByte), int'(sv));
  endtask

  initial begin
    void'($urandom(32'h1D2C3B4A));
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R1 busy in reset", int'(busy), 0);
    chk(ssN == 4'hF, "R1 R9 selects in reset", int'(ssN), 15);
    chk(sclk == 1'b0, "R1 sclk in reset", int'(sclk), 0);
    chk(rxByte == 8'h00, "R1 rxByte in reset", int'(rxByte), 0);
    rstN = 1'b1;
    @(negedge clk);

    // directed: all four modes at the fastest divider, each slave
    xfer(1'b0, 1'b0, 8'd0, 2'd0, 8'hAA, 8'h55, 1'b0);
    xfer(1'b0, 1'b1, 8'd0, 2'd1, 8'h81, 8'h7E, 1'b0);
    xfer(1'b1, 1'b0, 8'd0, 2'd2, 8'h01, 8'h80, 1'b0);
    xfer(1'b1, 1'b1, 8'd0, 2'd3, 8'hAA, 8'h00, 1'b0);
    // directed: slow divider, all-ones and all-zeros bytes
    xfer(1'b1, 1'b1, 8'd7, 2'd1, 8'hFF, 8'hC3, 1'b0);
    xfer(1'b0, 1'b0, 8'd3, 2'd2, 8'h00, 8'hFF, 1'b0);
    // directed: inputs disturbed and enable pulsed mid-transfer
    xfer(1'b0, 1'b1, 8'd2, 2'd0, 8'h96, 8'h3C, 1'b1);
    xfer(1'b1, 1'b0, 8'd0, 2'd3, 8'h5A, 8'hA5, 1'b1);

    // random transfers
    for (int i = 0; i < 24; i++) begin
      xfer(1'($urandom), 1'($urandom), 8'($urandom % 4), 2'($urandom),
           8'($urandom), 8'($urandom), 1'(($urandom % 4) == 0));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule